// File: doc/BRIEF.md
# Packet Summary Ring Producer

The block takes one packet summary at a time from the reassembly logic and writes it as a fixed two-word entry into a circular array in host memory. Each entry holds the packet length, the circuit number, the transport checksum and an ownership bit. Software scans the array and stops at the first entry whose ownership bit does not match the sense it expects for the current pass, so it never has to read a device register to find new work. Once it has processed a run of entries, it hands all of them back with a single write of its consumer index.

Software sets the ring base address and the number of entries through a small register write port. The current producer index is always visible on an output. One producer and one consumer index make up the ring state. The ring is empty when they are equal. It is full when advancing the producer would make it equal to the consumer. While the ring is full, the summary input is held off. Each entry goes out as a sequence of single-word write requests. The ownership word always goes last, and the producer index moves only once the whole entry has been acknowledged.

Top module: `sumring_producer`

## Requirements
- R1: After reset the producer index is 0, no memory write is requested, the ring holds 4 entries, the consumer index is 0, and the summary input is ready.
- R2: Entry word 0 carries the checksum in bits 31:16 and the packet length in bits 15:0. Entry word 1 carries the ownership bit in bit 31 and the circuit number in bits 11:0, with bits 30:12 at zero.
- R3: Word w of entry i is written at address base + 8*i + 4*w. Bits 2:0 of the written base value are ignored. Word 0 is requested in the cycle after a summary is accepted, and word 1 (the ownership word) is requested only after word 0 has been acknowledged.
- R4: A write request holds its address and data unchanged until it is acknowledged.
- R5: The producer index steps by one, wrapping from length-1 to 0, in the cycle after the last word of an entry is acknowledged. It never changes before that point.
- R6: The ownership bit is 1 for every entry written on the first pass after a length write or reset, and it inverts each time the producer index wraps to 0.
- R7: When the next producer index equals the consumer index, the ring is full: ready is low, a waiting summary is not taken, and nothing is written. When the ring is empty (producer equals consumer), a summary is accepted.
- R8: One write of the consumer index (register select 2, low index bits) frees every entry up to it at once, and ready returns in the cycle after that write.
- R9: A write to register select 1 sets the ring length, with values below 2 read as 2 and values above 16 read as 16 (the default index width is 4). The same write clears the producer and consumer indices and restores the ownership sense to 1. Register select 0 sets the base address.
- R10: A summary is accepted only while no entry write is in progress. Ready stays low from the acceptance until the entry's last acknowledgement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sum_valid_i | input | 1 | Summary offered |
| sum_ready_o | output | 1 | Summary taken when high with valid |
| sum_len_i | input | 16 | Packet length |
| sum_circ_i | input | 12 | Circuit number |
| sum_csum_i | input | 16 | Transport checksum |
| mem_req_o | output | 1 | Memory word write request |
| mem_addr_o | output | ADDR_W | Byte address of the word |
| mem_data_o | output | 32 | Word to write |
| mem_ack_i | input | 1 | Request completed this cycle |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register select: 0 base, 1 length, 2 consumer index |
| reg_wdata_i | input | 32 | Register write data |
| prod_idx_o | output | IDX_W | Current producer index |

## Verification
Ring lengths from the clamped minimum up to the clamped maximum are each filled to the full point, over three passes, with acknowledge latencies that rotate between zero and two wait cycles. This separates correct address arithmetic and wrap points per length from an off-by-one error in the full test or the wrap test. Holding a summary against a full ring, and then freeing a single entry before freeing the rest, distinguishes real back-pressure and bulk recycling from a ring that overwrites entries or gives them back one at a time. Checking the ownership bit on every pass shows whether its sense flips exactly at the wrap. Comparing the producer index between the two acknowledgements shows whether it moves early.

// File: rtl/sumring_pkg.sv
package sumring_pkg;
  localparam int WORD_W      = 32;
  localparam int WORD_BYTES  = 4;
  localparam int ENTRY_WORDS = 2;
  localparam int PKT_LEN_W   = 16;
  localparam int CSUM_W      = 16;
  localparam int CIRC_W      = 12;
  localparam int WSEL_W      = $clog2(ENTRY_WORDS);
  localparam int BYTE_SHIFT  = $clog2(WORD_BYTES);
  localparam int ENTRY_SHIFT = $clog2(ENTRY_WORDS * WORD_BYTES);

  typedef struct packed {
    logic [CSUM_W-1:0]    csum;
    logic [PKT_LEN_W-1:0] plen;
    logic [CIRC_W-1:0]    circ;
  } summary_t;

  typedef enum logic [1:0] {
    REG_BASE = 2'd0,
    REG_LEN  = 2'd1,
    REG_CONS = 2'd2
  } reg_sel_e;

  typedef enum logic {
    WR_IDLE = 1'b0,
    WR_BUSY = 1'b1
  } wr_state_e;

  // ownership word is the highest-numbered word, so it goes out last
  function automatic logic [WORD_W-1:0] entry_word(summary_t s, logic own,
                                                   logic [WSEL_W-1:0] w);
    if (w == '0) return {s.csum, s.plen};
    return {own, {(WORD_W-1-CIRC_W){1'b0}}, s.circ};
  endfunction
endpackage

// File: rtl/sumring_regs.sv
module sumring_regs
  import sumring_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int IDX_W   = 4,
  parameter int LEN_RST = 4,
  localparam int LEN_W  = IDX_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [1:0]        reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [ADDR_W-1:0] base_o,
  output logic [LEN_W-1:0]  eff_len_o,
  output logic [IDX_W-1:0]  cons_o,
  output logic              reinit_o
);
  localparam int MAX_LEN = 1 << IDX_W;

  function automatic logic [LEN_W-1:0] clamp_len(logic [31:0] v);
    if (v < 32'd2) return LEN_W'(2);
    if (v > 32'(MAX_LEN)) return LEN_W'(MAX_LEN);
    return v[LEN_W-1:0];
  endfunction

  logic [ADDR_W-1:0] base_q;
  logic [LEN_W-1:0]  len_q;
  logic [IDX_W-1:0]  cons_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= '0;
      len_q  <= clamp_len(32'(LEN_RST));
      cons_q <= '0;
    end else if (reg_we_i) begin
      case (reg_addr_i)
        REG_BASE: base_q <= {reg_wdata_i[ADDR_W-1:ENTRY_SHIFT], {ENTRY_SHIFT{1'b0}}};
        REG_LEN: begin
          len_q  <= clamp_len(reg_wdata_i);
          cons_q <= '0;
        end
        REG_CONS: cons_q <= reg_wdata_i[IDX_W-1:0];
        default: ;
      endcase
    end
  end

  assign base_o    = base_q;
  assign eff_len_o = len_q;
  assign cons_o    = cons_q;
  assign reinit_o  = reg_we_i && (reg_addr_i == REG_LEN);
endmodule

// File: rtl/sumring_index.sv
module sumring_index #(
  parameter int IDX_W  = 4,
  localparam int LEN_W = IDX_W + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             reinit_i,
  input  logic             adv_i,
  input  logic [LEN_W-1:0] eff_len_i,
  input  logic [IDX_W-1:0] cons_i,
  output logic [IDX_W-1:0] prod_o,
  output logic             phase_o,
  output logic             full_o
);
  logic [IDX_W-1:0] prod_q, prod_nxt;
  logic             phase_q, at_end;

  assign at_end   = ({1'b0, prod_q} == (eff_len_i - 1'b1));
  assign prod_nxt = at_end ? '0 : prod_q + 1'b1;
  assign full_o   = (prod_nxt == cons_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prod_q  <= '0;
      phase_q <= 1'b1;
    end else if (reinit_i) begin
      prod_q  <= '0;
      phase_q <= 1'b1;
    end else if (adv_i) begin
      prod_q <= prod_nxt;
      if (at_end) phase_q <= ~phase_q;
    end
  end

  assign prod_o  = prod_q;
  assign phase_o = phase_q;
endmodule

// File: rtl/sumring_writer.sv
module sumring_writer
  import sumring_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sum_valid_i,
  input  summary_t          sum_i,
  output logic              sum_ready_o,
  input  logic              full_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [IDX_W-1:0]  prod_i,
  input  logic              phase_i,
  output logic              mem_req_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [WORD_W-1:0] mem_data_o,
  input  logic              mem_ack_i,
  output logic              adv_o,
  output logic              last_word_o
);
  localparam int OFFS_W = IDX_W + WSEL_W;

  wr_state_e         state_q;
  logic [WSEL_W-1:0] wsel_q;
  summary_t          sum_q;
  logic [WORD_W-1:0] words [ENTRY_WORDS];
  logic [OFFS_W-1:0] offs;
  logic              accept, last_word;

  assign sum_ready_o = (state_q == WR_IDLE) && !full_i;
  assign accept      = sum_valid_i && sum_ready_o;
  assign last_word   = (wsel_q == WSEL_W'(ENTRY_WORDS - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= WR_IDLE;
      wsel_q  <= '0;
      sum_q   <= '0;
    end else begin
      case (state_q)
        WR_IDLE: if (accept) begin
          sum_q   <= sum_i;
          wsel_q  <= '0;
          state_q <= WR_BUSY;
        end
        WR_BUSY: if (mem_ack_i) begin
          if (last_word) state_q <= WR_IDLE;
          else           wsel_q  <= wsel_q + 1'b1;
        end
        default: state_q <= WR_IDLE;
      endcase
    end
  end

  for (genvar g = 0; g < ENTRY_WORDS; g++) begin : g_word
    assign words[g] = entry_word(sum_q, phase_i, WSEL_W'(g));
  end

  assign offs        = {prod_i, wsel_q};
  assign mem_req_o   = (state_q == WR_BUSY);
  assign mem_addr_o  = base_i + (ADDR_W'(offs) << BYTE_SHIFT);
  assign mem_data_o  = words[wsel_q];
  assign adv_o       = mem_req_o && mem_ack_i && last_word;
  assign last_word_o = last_word;
endmodule

// File: rtl/sumring_producer.sv
module sumring_producer
  import sumring_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int IDX_W   = 4,
  parameter int LEN_RST = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sum_valid_i,
  output logic              sum_ready_o,
  input  logic [15:0]       sum_len_i,
  input  logic [11:0]       sum_circ_i,
  input  logic [15:0]       sum_csum_i,
  output logic              mem_req_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [31:0]       mem_data_o,
  input  logic              mem_ack_i,
  input  logic              reg_we_i,
  input  logic [1:0]        reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [IDX_W-1:0]  prod_idx_o
);
  localparam int LEN_W = IDX_W + 1;

  logic [ADDR_W-1:0] base_w;
  logic [LEN_W-1:0]  eff_len_w;
  logic [IDX_W-1:0]  cons_w, prod_w;
  logic              reinit_w, adv_w, phase_w, full_w, last_word_w;
  summary_t          sum_w;

  assign sum_w = '{csum: sum_csum_i, plen: sum_len_i, circ: sum_circ_i};

  sumring_regs #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .LEN_RST(LEN_RST)) u_regs (
    .clk_i, .rst_ni, .reg_we_i, .reg_addr_i, .reg_wdata_i,
    .base_o(base_w), .eff_len_o(eff_len_w), .cons_o(cons_w), .reinit_o(reinit_w)
  );

  sumring_index #(.IDX_W(IDX_W)) u_index (
    .clk_i, .rst_ni, .reinit_i(reinit_w), .adv_i(adv_w),
    .eff_len_i(eff_len_w), .cons_i(cons_w),
    .prod_o(prod_w), .phase_o(phase_w), .full_o(full_w)
  );

  sumring_writer #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_writer (
    .clk_i, .rst_ni, .sum_valid_i, .sum_i(sum_w), .sum_ready_o,
    .full_i(full_w), .base_i(base_w), .prod_i(prod_w), .phase_i(phase_w),
    .mem_req_o, .mem_addr_o, .mem_data_o, .mem_ack_i,
    .adv_o(adv_w), .last_word_o(last_word_w)
  );

  assign prod_idx_o = prod_w;
endmodule

// File: rtl/sumring_producer_chk.sv
module sumring_producer_chk #(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              sum_valid_i,
  input logic              sum_ready_o,
  input logic              mem_req_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic [31:0]       mem_data_o,
  input logic              mem_ack_i,
  input logic              reg_we_i,
  input logic [IDX_W-1:0]  prod_idx_o,
  input logic              full_w,
  input logic              last_word_w,
  input logic [IDX_W:0]    eff_len_w
);
  AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ack_i |=> mem_req_o && $stable(mem_addr_o) && $stable(mem_data_o)); // R4
  AST_WRITE_STARTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sum_valid_i && sum_ready_o |=> mem_req_o); // R3
  AST_BUSY_NO_ACCEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !(mem_ack_i && last_word_w) |=> !sum_ready_o); // R10
  AST_FULL_BLOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_w |-> !sum_ready_o); // R7
  AST_PROD_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_req_o && mem_ack_i && last_word_w) && !reg_we_i |=> $stable(prod_idx_o)); // R5
  AST_PROD_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    {1'b0, prod_idx_o} < eff_len_w); // R5
endmodule

bind sumring_producer sumring_producer_chk #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .sum_valid_i(sum_valid_i), .sum_ready_o(sum_ready_o),
  .mem_req_o(mem_req_o), .mem_addr_o(mem_addr_o), .mem_data_o(mem_data_o),
  .mem_ack_i(mem_ack_i), .reg_we_i(reg_we_i), .prod_idx_o(prod_idx_o),
  .full_w(full_w), .last_word_w(last_word_w), .eff_len_w(eff_len_w)
);

// File: tb/sumring_producer_bench.sv
`timescale 1ns/1ps
module sumring_producer_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        sum_valid_i = 1'b0;
  logic        sum_ready_o;
  logic [15:0] sum_len_i = '0;
  logic [11:0] sum_circ_i = '0;
  logic [15:0] sum_csum_i = '0;
  logic        mem_req_o;
  logic [31:0] mem_addr_o;
  logic [31:0] mem_data_o;
  logic        mem_ack_i = 1'b0;
  logic        reg_we_i = 1'b0;
  logic [1:0]  reg_addr_i = '0;
  logic [31:0] reg_wdata_i = '0;
  logic [3:0]  prod_idx_o;

  int n_chk = 0, n_fail = 0, pkt = 0;
  int m_len, m_prod, m_cons, m_phase;
  logic [31:0] m_base;
  bit done = 0;

  always #2 clk_i = ~clk_i;

  sumring_producer u_sumring_producer (.*);

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int nxt(input int p);
    return (p == m_len - 1) ? 0 : p + 1;
  endfunction

  task automatic reg_wr(input logic [1:0] a, input logic [31:0] d);
    reg_we_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk_i);
    reg_we_i = 1'b0;
  endtask

  task automatic set_len(input int v);
    reg_wr(2'd1, 32'(v));
    m_len = (v < 2) ? 2 : ((v > 16) ? 16 : v);
    m_prod = 0; m_cons = 0; m_phase = 1;
    check(prod_idx_o == 4'd0, "R9 prod cleared", prod_idx_o, 0);
  endtask

  task automatic set_cons(input int c);
    reg_wr(2'd2, 32'(c));
    m_cons = c;
    check(sum_ready_o == (nxt(m_prod) != m_cons), "R8 ready after consumer write",
          sum_ready_o, (nxt(m_prod) != m_cons));
  endtask

  task automatic serve_word(input int w, input logic [31:0] exp_d, input int waits);
    logic [31:0] exp_a;
    exp_a = m_base + 32'(m_prod * 8) + 32'(w * 4);
    check(mem_req_o == 1'b1, "R3 request present", mem_req_o, 1);
    check(mem_addr_o == exp_a, "R3 entry address", mem_addr_o, exp_a);
    check(mem_data_o == exp_d, (w == 1) ? "R6 R2 ownership word" : "R2 first word",
          mem_data_o, exp_d);
    check(sum_ready_o == 1'b0, "R10 busy not ready", sum_ready_o, 0);
    for (int i = 0; i < waits; i++) begin
      @(negedge clk_i);
      check(mem_req_o && mem_addr_o == exp_a && mem_data_o == exp_d, "R4 held until ack",
            mem_addr_o, exp_a);
    end
    mem_ack_i = 1'b1;
    @(negedge clk_i);
    mem_ack_i = 1'b0;
  endtask

  task automatic push(input int waits);
    logic [15:0] pl, cs;
    logic [11:0] ci;
    pl = 16'(pkt * 37 + m_len);
    cs = 16'hA000 ^ 16'(pkt);
    ci = 12'(pkt * 5 + 1);
    pkt++;
    check(sum_ready_o == 1'b1, "R7 not full ready", sum_ready_o, 1);
    sum_valid_i = 1'b1; sum_len_i = pl; sum_circ_i = ci; sum_csum_i = cs;
    @(negedge clk_i);
    sum_valid_i = 1'b0;
    serve_word(0, {cs, pl}, waits);
    check(prod_idx_o == 4'(m_prod), "R5 no early advance", prod_idx_o, m_prod);
    serve_word(1, {1'(m_phase), 19'd0, ci}, waits);
    if (nxt(m_prod) == 0) m_phase ^= 1;
    m_prod = nxt(m_prod);
    check(prod_idx_o == 4'(m_prod), "R5 advance after last ack", prod_idx_o, m_prod);
    check(mem_req_o == 1'b0, "R5 entry done", mem_req_o, 0);
  endtask

  task automatic hold_full();
    sum_valid_i = 1'b1;
    for (int i = 0; i < 3; i++) begin
      check(sum_ready_o == 1'b0, "R7 full not ready", sum_ready_o, 0);
      @(negedge clk_i);
      check(mem_req_o == 1'b0 && prod_idx_o == 4'(m_prod), "R7 nothing written",
            mem_req_o, 0);
    end
    sum_valid_i = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int lens[6] = '{1, 3, 5, 7, 16, 20};
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check(prod_idx_o == 4'd0, "R1 prod reset", prod_idx_o, 0);
    check(mem_req_o == 1'b0, "R1 no request", mem_req_o, 0);
    check(sum_ready_o == 1'b1, "R1 ready", sum_ready_o, 1);
    m_len = 4; m_prod = 0; m_cons = 0; m_phase = 1; m_base = '0;
    for (int k = 0; k < 3; k++) push(k);
    hold_full(); // R1 default length 4: full after 3 entries
    foreach (lens[li]) begin
      reg_wr(2'd0, 32'h4000_0000 + 32'(lens[li] * 256) + 32'd5);
      m_base = 32'h4000_0000 + 32'(lens[li] * 256);
      set_len(lens[li]);
      for (int pass = 0; pass < 3; pass++) begin
        while (nxt(m_prod) != m_cons) push(pkt % 3);
        hold_full();
        set_cons(nxt(m_cons));
        push(1);
        hold_full();
        set_cons(m_prod);
        check(sum_ready_o == 1'b1, "R7 empty ready", sum_ready_o, 1);
      end
    end
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule